// File: doc/BRIEF.md
# Daisy-Chain Bus Grant Arbiter

This block decides which of several devices on one shared bus may drive it. Each device raises its own request bit, and the OR of those bits forms a common request line. A single grant token enters the chain at one device and travels device by device. A device that does not want the bus lets the token pass on. The first requesting device it reaches keeps the token and becomes the bus owner. While any device owns the bus, a shared busy output is high and no new grant is issued. The owner gives up the bus by pulsing its done input.

A parameter selects one of two modes. In fixed mode the token always enters at device 0, which is the device nearest the channel. Lower indices therefore always win. In rotating mode the token enters wherever the last owner left it. When an owner finishes while the request line is still active, the token is parked at the next device in the chain, wrapping from the last device back to device 0. If no request is pending at that moment, the token is withdrawn and the next grant starts again at device 0.

The token passes along the chain within one cycle, through combinational logic. Ownership and busy are registered, and an active-low asynchronous reset clears both. The data, address and control transfers on the bus are outside this block.

Top module: `daisy_arbiter`

## Requirements
- R1: During and immediately after reset, owner_o and grant_o are all zero and busy_o is low.
- R2: grant_o is all zero in any cycle where no request bit is set or busy_o is high.
- R3: When a grant is issued, grant_o is set on every device from the entry device up to and including the first requesting device in chain order, and is zero on all other devices.
- R4: The first requesting device reached by the token becomes the owner at the next clock edge, and busy_o goes high at that same edge.
- R5: At most one bit of owner_o is set at any time, and busy_o is high exactly when one bit is set.
- R6: An owner keeps the bus until its own done bit is sampled high. Done bits from other devices, and any changes to the request bits, have no effect on ownership during that time.
- R7: When the owner's done bit is sampled high, owner_o and busy_o clear at that edge. A new grant can then be issued in the very next cycle.
- R8: In fixed mode the token always enters at device 0, so the lowest-index requester wins.
- R9: In rotating mode, if any request bit is set in the cycle the owner finishes, the next grant enters at owner index plus one. The index wraps from N_DEV-1 to 0, and the token ripples around the chain with wrap-around.
- R10: In rotating mode, if no request bit is set in the cycle the owner finishes, the token is withdrawn and the next grant enters at device 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | N_DEV | Per-device bus request |
| done_i | input | N_DEV | Per-device end-of-transfer pulse; only the owner's bit matters |
| grant_o | output | N_DEV | Grant token present at each device this cycle |
| owner_o | output | N_DEV | One-hot current bus owner |
| busy_o | output | 1 | Shared busy line |

## Verification
The hardest case to reach is a rotating-mode token that enters partway along the chain and has to wrap past the last device before it finds a requester. Reaching it needs a chain of handovers: one owner finishes with requests still pending, which parks the token beyond device 0. An idle cycle then leaves that parked position unchanged. Only then do requests appear, and only below the entry point. A separate sequence ends an ownership with no request pending, so that the bench can tell a withdrawn token (entry at device 0) apart from a parked one.

// File: rtl/dcarb_pkg.sv
package dcarb_pkg;
  typedef enum logic {
    ARB_FIXED  = 1'b0,
    ARB_ROTATE = 1'b1
  } arb_mode_e;
endpackage

// File: rtl/dcarb_ripple.sv
module dcarb_ripple
  import dcarb_pkg::*;
#(
  parameter int        N_DEV = 4,
  parameter arb_mode_e MODE  = ARB_FIXED,
  parameter int        IDX_W = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
  input  logic             inject_i,
  input  logic [N_DEV-1:0] req_i,
  input  logic [IDX_W-1:0] start_i,
  output logic [N_DEV-1:0] grant_o,
  output logic [N_DEV-1:0] take_o
);
  // chain-order view: position 0 is the entry device
  logic [N_DEV-1:0] rreq, rgnt, rtake;
  logic [N_DEV:0]   chain;

  assign chain[0] = inject_i;

  for (genvar i = 0; i < N_DEV; i++) begin : g_stage
    assign rgnt[i]    = chain[i];
    assign rtake[i]   = chain[i] & rreq[i];
    assign chain[i+1] = chain[i] & ~rreq[i];
  end

  logic unused_tail;
  assign unused_tail = chain[N_DEV];

  if (MODE == ARB_ROTATE) begin : g_rot
    logic [2*N_DEV-1:0] req2, gnt2, take2;
    assign req2    = {req_i, req_i} >> start_i;
    assign rreq    = req2[N_DEV-1:0];
    assign gnt2    = {rgnt, rgnt} << start_i;
    assign take2   = {rtake, rtake} << start_i;
    assign grant_o = gnt2[2*N_DEV-1:N_DEV];
    assign take_o  = take2[2*N_DEV-1:N_DEV];
    logic unused_rot;
    assign unused_rot = ^{req2[2*N_DEV-1:N_DEV], gnt2[N_DEV-1:0], take2[N_DEV-1:0]};
  end else begin : g_fix
    logic unused_start;
    assign unused_start = ^start_i;
    assign rreq    = req_i;
    assign grant_o = rgnt;
    assign take_o  = rtake;
  end
endmodule

// File: rtl/dcarb_node.sv
module dcarb_node (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic take_i,
  input  logic done_i,
  output logic own_o
);
  logic own_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               own_q <= 1'b0;
    else if (own_q && done_i)  own_q <= 1'b0;
    else if (take_i)           own_q <= 1'b1;
  end

  assign own_o = own_q;

  assert_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_o && done_i) |=> !own_o);
  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (own_o && !done_i) |=> own_o);
endmodule

// File: rtl/dcarb_channel.sv
module dcarb_channel
  import dcarb_pkg::*;
#(
  parameter int        N_DEV = 4,
  parameter arb_mode_e MODE  = ARB_FIXED,
  parameter int        IDX_W = (N_DEV > 1) ? $clog2(N_DEV) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_DEV-1:0] req_i,
  input  logic [N_DEV-1:0] done_i,
  input  logic [N_DEV-1:0] own_i,
  input  logic [N_DEV-1:0] take_i,
  output logic             busy_o,
  output logic             inject_o,
  output logic [IDX_W-1:0] start_o
);
  logic busy_q, req_line, release_w;

  assign req_line  = |req_i;
  assign release_w = |(own_i & done_i);
  assign inject_o  = req_line & ~busy_q;
  assign busy_o    = busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        busy_q <= 1'b0;
    else if (release_w) busy_q <= 1'b0;
    else if (|take_i)   busy_q <= 1'b1;
  end

  if (MODE == ARB_ROTATE) begin : g_ptr
    logic [IDX_W-1:0] ptr_q, own_idx;

    always_comb begin
      own_idx = '0;
      for (int i = 0; i < N_DEV; i++)
        if (own_i[i]) own_idx = IDX_W'(i);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ptr_q <= '0;
      else if (release_w) begin
        if (!req_line)                          ptr_q <= '0;
        else if (own_idx == IDX_W'(N_DEV - 1))  ptr_q <= '0;
        else                                    ptr_q <= own_idx + 1'b1;
      end
    end

    assign start_o = ptr_q;

    assert_wrap_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (release_w && req_line && own_i[N_DEV-1]) |=> (start_o == '0));
    assert_withdraw_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (release_w && !req_line) |=> (start_o == '0));
  end else begin : g_noptr
    assign start_o = '0;
  end

  assert_busy_owner_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o == (|own_i));
  assert_capture_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inject_o |=> busy_o);
endmodule

// File: rtl/daisy_arbiter.sv
module daisy_arbiter
  import dcarb_pkg::*;
#(
  parameter int        N_DEV = 4,
  parameter arb_mode_e MODE  = ARB_FIXED
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_DEV-1:0] req_i,
  input  logic [N_DEV-1:0] done_i,
  output logic [N_DEV-1:0] grant_o,
  output logic [N_DEV-1:0] owner_o,
  output logic             busy_o
);
  localparam int IDX_W = (N_DEV > 1) ? $clog2(N_DEV) : 1;

  logic             inject;
  logic [IDX_W-1:0] start;
  logic [N_DEV-1:0] take, own;

  dcarb_channel #(.N_DEV(N_DEV), .MODE(MODE), .IDX_W(IDX_W)) u_channel (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .done_i   (done_i),
    .own_i    (own),
    .take_i   (take),
    .busy_o   (busy_o),
    .inject_o (inject),
    .start_o  (start)
  );

  dcarb_ripple #(.N_DEV(N_DEV), .MODE(MODE), .IDX_W(IDX_W)) u_ripple (
    .inject_i (inject),
    .req_i    (req_i),
    .start_i  (start),
    .grant_o  (grant_o),
    .take_o   (take)
  );

  for (genvar i = 0; i < N_DEV; i++) begin : g_node
    dcarb_node u_node (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .take_i (take[i]),
      .done_i (done_i[i]),
      .own_o  (own[i])
    );
  end

  assign owner_o = own;

  assert_one_owner_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(owner_o));
  assert_no_grant_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |-> (grant_o == '0));
  assert_single_take_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(take));
  assert_owner_stable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((owner_o != '0) && ((owner_o & done_i) == '0)) |=> $stable(owner_o));
endmodule

// File: tb/daisy_arbiter_tb_top.sv
module daisy_arbiter_tb_top;
  import dcarb_pkg::*;
  localparam int N = 4;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_ni;
  logic [N-1:0] req_p = '0, done_p = '0, req_r = '0, done_r = '0;
  logic [N-1:0] gnt_p, own_p, gnt_r, own_r;
  logic busy_p, busy_r;

  daisy_arbiter #(.N_DEV(N), .MODE(ARB_FIXED)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_p), .done_i(done_p),
    .grant_o(gnt_p), .owner_o(own_p), .busy_o(busy_p));

  daisy_arbiter #(.N_DEV(N), .MODE(ARB_ROTATE)) dut_rr_i (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req_r), .done_i(done_r),
    .grant_o(gnt_r), .owner_o(own_r), .busy_o(busy_r));

  typedef struct {
    bit          rr;
    logic [N-1:0] own;
    string       tag;
  } exp_t;

  exp_t q[$];
  exp_t cur;
  int m_own[2];
  int m_ptr[2];
  int pass_c = 0, total_c = 0;
  bit finished = 0;

  task automatic chk(string tag, string what, logic [N-1:0] act, logic [N-1:0] exp);
    total_c++;
    if (act === exp) pass_c++;
    else $display("FAIL %s %s act=%b exp=%b", tag, what, act, exp);
  endtask

  // driver: apply inputs, check grant ripple, push expected owner
  task automatic step(bit rr, logic [N-1:0] rq, logic [N-1:0] dn, string tag);
    int m, o, win, st;
    logic [N-1:0] eg, eo;
    exp_t e;
    @(negedge clk);
    if (rr) begin req_r = rq; done_r = dn; req_p = '0; done_p = '0; end
    else    begin req_p = rq; done_p = dn; req_r = '0; done_r = '0; end
    #1;
    m = rr ? 1 : 0;
    o = m_own[m];
    eg = '0;
    win = -1;
    if (o < 0 && rq != '0) begin
      st = rr ? m_ptr[m] : 0;
      for (int i = 0; i < N; i++) begin
        int p;
        p = (st + i) % N;
        eg[p] = 1'b1;
        if (rq[p]) begin win = p; break; end
      end
    end
    chk(tag, "grant", rr ? gnt_r : gnt_p, eg);
    if (o >= 0) begin
      if (dn[o]) begin
        m_own[m] = -1;
        if (rr) m_ptr[m] = (rq != '0) ? (o + 1) % N : 0;
      end
    end else if (win >= 0) begin
      m_own[m] = win;
    end
    eo = '0;
    if (m_own[m] >= 0) eo[m_own[m]] = 1'b1;
    e.rr = rr; e.own = eo; e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: compare registered outputs after each edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (q.size() > 0) begin
        cur = q.pop_front();
        chk(cur.tag, "owner", cur.rr ? own_r : own_p, cur.own);
        chk("R5", "busy", {{(N-1){1'b0}}, cur.rr ? busy_r : busy_p},
            {{(N-1){1'b0}}, |cur.own});
      end
    end
  end

  initial begin
    #500000;
    if (!finished) begin
      total_c++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("%0d/%0d checks passed", pass_c, total_c);
      $finish;
    end
  end

  initial begin
    m_own[0] = -1; m_own[1] = -1; m_ptr[0] = 0; m_ptr[1] = 0;
    rst_ni = 1'b0;
    #12;
    chk("R1", "owner fixed", own_p, '0);
    chk("R1", "owner rot", own_r, '0);
    chk("R1", "busy", {2'b0, busy_p, busy_r}, '0);
    chk("R1", "grant", gnt_p | gnt_r, '0);
    @(negedge clk);
    rst_ni = 1'b1;

    // fixed priority
    step(0, 4'b0000, 4'b0000, "R2");
    step(0, 4'b0100, 4'b0000, "R3");
    step(0, 4'b0101, 4'b0001, "R6");
    step(0, 4'b0101, 4'b0000, "R6");
    step(0, 4'b0101, 4'b0100, "R7");
    step(0, 4'b0101, 4'b0000, "R8");
    step(0, 4'b1100, 4'b0001, "R7");
    step(0, 4'b1100, 4'b0000, "R8");
    step(0, 4'b1000, 4'b0100, "R7");
    step(0, 4'b1000, 4'b0000, "R3");
    step(0, 4'b0000, 4'b1000, "R7");
    step(0, 4'b0000, 4'b0000, "R2");

    // rotating
    step(1, 4'b0011, 4'b0000, "R4");
    step(1, 4'b0011, 4'b0001, "R9");
    step(1, 4'b0011, 4'b0000, "R9");
    step(1, 4'b1001, 4'b0010, "R9");
    step(1, 4'b1001, 4'b0000, "R9");
    step(1, 4'b1001, 4'b1000, "R9");
    step(1, 4'b1001, 4'b0000, "R9");
    step(1, 4'b0000, 4'b0001, "R10");
    step(1, 4'b0110, 4'b0000, "R10");
    step(1, 4'b0110, 4'b0010, "R9");
    step(1, 4'b0000, 4'b0000, "R2");
    step(1, 4'b0011, 4'b0000, "R9");
    step(1, 4'b0000, 4'b0001, "R7");
    step(1, 4'b0000, 4'b0000, "R2");

    repeat (3) @(negedge clk);
    finished = 1;
    $display("%0d/%0d checks passed", pass_c, total_c);
    $finish;
  end
endmodule